// File: doc/BRIEF.md
# Frame Timing Mode Controller

This block picks the timing reference for a telecom frame generator and keeps the 8 kHz frame position. A 3-bit mode field chooses what drives an external phase-locked loop. The choices are:

- the prescaled local oscillator;
- one of three 8 kHz references (recovered, external A, external B);
- a backplane 4 MHz clock.

The same field decides whether the frame counter free-runs, stays only frequency-locked, or is snapped back to zero on the rising edge of the selected reference or of the backplane frame pulse.

The loop itself sits outside the block. Its output returns as `tick_i`, a 4.096 MHz enable that is synchronous to `clk`. A frame is 512 ticks. The counter drives a frame pulse and exposes its position. A 2-bit divide field sets how the local oscillator is prescaled, and is checked against the mode. A requested mode change waits for the next frame wrap, so that no runt frame is produced. A return to free-running mode is the one exception and takes effect at once.

Top module: `frame_timing_ctrl`

## Requirements
- R1: After reset, `active_mode_o` is 0, `master_o` is 1, `frame_pos_o` is 0, `frame_pulse_o` is 1, `ref_sel_o` is 0 and `config_error_o` is 0.
- R2: `osc_en_o` is high once every 4 clocks for divide field 00, every 2 clocks for 01, and every clock for 10. The reserved code 11 prescales by 4.
- R3: `ref_sel_o` is 0 in active mode 0 (local prescaled oscillator), 1 in modes 1 and 5 (recovered), 2 in modes 2 and 6 (external A), 3 in modes 3 and 7 (external B), and 4 in mode 4 (backplane clock). `ref_o` carries the signal so selected.
- R4: `frame_pos_o` advances by one on each clock where `tick_i` is high, holds when `tick_i` is low, and wraps from 511 to 0. `frame_pulse_o` is high exactly while the position is 0.
- R5: In active modes 0 to 3, edges on the reference inputs and on `bp_fp_i` never move the frame position.
- R6: In active modes 4 to 7, a rising edge on the aligning input reloads the position to 0. The aligning input is `bp_fp_i` in mode 4, recovered in mode 5, A in mode 6 and B in mode 7. The reload is visible after the third rising clock edge counted from the input change. Edges on the other inputs are ignored.
- R7: An aligning edge that lands while the position is already 0 does not reload. The count moves on to 1, so no second frame pulse appears.
- R8: `master_o` is low only while the active mode is 4.
- R9: A request for a non-zero mode becomes active on the clock edge where the counter wraps from 511 to 0. Until then `active_mode_o` keeps its old value.
- R10: A request for mode 0 becomes active on the next clock edge.
- R11: One clock after the inputs change, `config_error_o` is high when the divide field is 11, or when the divide field is non-zero while the requested mode is non-zero. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Requested timing mode |
| xdiv_i | input | 2 | Oscillator divide field |
| tick_i | input | 1 | 4.096 MHz enable from the loop output |
| ref_rec_i | input | 1 | Recovered 8 kHz reference |
| ref_a_i | input | 1 | External 8 kHz reference A |
| ref_b_i | input | 1 | External 8 kHz reference B |
| bp_c4_i | input | 1 | Backplane 4 MHz clock |
| bp_fp_i | input | 1 | Backplane frame pulse |
| osc_en_o | output | 1 | Prescaled local oscillator enable |
| ref_sel_o | output | 3 | Code of the reference driving the loop |
| ref_o | output | 1 | Selected loop reference signal |
| frame_pulse_o | output | 1 | High while the frame position is 0 |
| frame_pos_o | output | 9 | Frame position in ticks |
| master_o | output | 1 | Timing master flag |
| active_mode_o | output | 3 | Mode currently in force |
| config_error_o | output | 1 | Divide field inconsistent with mode |

## Verification
Two events can land on the same clock edge: the counter's own return to zero, and a realignment edge from the synchroniser. To force them together, the bench raises the recovered reference while mode 5 is active and the position reads 510. After two clock edges the position is 0 and the pulse is high. The synchronised edge arrives on the third clock edge. The bench then expects position 1 and a low pulse, not a second reload to 0. A second pairing is a mode request against the frame wrap. A pending mode 7 must still be absent at position 511, and it must appear together with position 0 on the next clock edge.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  typedef enum logic [2:0] {
    MODE_FREE       = 3'd0,
    MODE_FREQ_REC   = 3'd1,
    MODE_FREQ_A     = 3'd2,
    MODE_FREQ_B     = 3'd3,
    MODE_BP_SLAVE   = 3'd4,
    MODE_ALIGN_REC  = 3'd5,
    MODE_ALIGN_A    = 3'd6,
    MODE_ALIGN_B    = 3'd7
  } tmode_e;

  typedef enum logic [2:0] {
    RSEL_LOCAL = 3'd0,
    RSEL_REC   = 3'd1,
    RSEL_A     = 3'd2,
    RSEL_B     = 3'd3,
    RSEL_BP    = 3'd4
  } rsel_e;

  // aligning source slots; slot index equals the low two mode bits
  localparam int NUM_SRC = 4;
  localparam int SRC_BP  = 0;
  localparam int SRC_REC = 1;
  localparam int SRC_A   = 2;
  localparam int SRC_B   = 3;

  function automatic logic mode_aligns(input logic [2:0] m);
    return m[2];
  endfunction

  function automatic rsel_e mode_to_rsel(input logic [2:0] m);
    rsel_e r;
    if (m == MODE_FREE)          r = RSEL_LOCAL;
    else if (m == MODE_BP_SLAVE) r = RSEL_BP;
    else                         r = rsel_e'({1'b0, m[1:0]});
    return r;
  endfunction

endpackage

// File: rtl/ftc_prescaler.sv
module ftc_prescaler #(
  parameter int CNT_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_code_i,
  output logic       en_o
);

  logic [CNT_W-1:0] ratio_m1;
  logic [CNT_W-1:0] pcnt_q;
  logic [CNT_W-1:0] pcnt_d;

  // divide code to terminal count: 00 -> /4, 01 -> /2, 10 -> /1, 11 -> /4
  always_comb begin
    case (div_code_i)
      2'b01:   ratio_m1 = CNT_W'(1);
      2'b10:   ratio_m1 = CNT_W'(0);
      default: ratio_m1 = CNT_W'(3);
    endcase
  end

  always_comb begin
    if (pcnt_q >= ratio_m1) pcnt_d = '0;
    else                    pcnt_d = pcnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign en_o = (pcnt_q == '0);

  assert_div1_every_clock_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_m1 == '0) |=> en_o);

  assert_no_back_to_back_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_m1 != '0 && en_o) |=> !en_o);

endmodule

// File: rtl/ftc_edge_sync.sv
module ftc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic meta_q;
  logic sync_q;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;

  assert_rise_single_cycle_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/ftc_frame_counter.sv
module ftc_frame_counter #(
  parameter int FRAME_LEN = 512,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          align_i,
  output logic [CW-1:0] pos_o,
  output logic          wrap_o,
  output logic          pulse_o
);

  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

  logic [CW-1:0] pos_q;
  logic [CW-1:0] pos_d;
  logic          reload;

  // a reload only when not already at zero, so no doubled pulse
  assign reload = align_i && (pos_q != '0);
  assign wrap_o = tick_i && (pos_q == LAST);

  always_comb begin
    pos_d = pos_q;
    if (reload)      pos_d = '0;
    else if (wrap_o) pos_d = '0;
    else if (tick_i) pos_d = pos_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos_o   = pos_q;
  assign pulse_o = (pos_q == '0);

  assert_advance_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !align_i && pos_q != LAST) |=> (pos_q == $past(pos_q) + CW'(1)));

  assert_hold_no_tick_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !align_i) |=> $stable(pos_q));

  assert_realign_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (align_i && pos_q != '0) |=> (pos_q == '0));

  assert_no_double_pulse_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (align_i && tick_i && pos_q == '0) |=> !pulse_o);

endmodule

// File: rtl/frame_timing_ctrl.sv
module frame_timing_ctrl
  import ftc_pkg::*;
#(
  parameter int FRAME_LEN = 512
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2:0]                   mode_i,
  input  logic [1:0]                   xdiv_i,
  input  logic                         tick_i,
  input  logic                         ref_rec_i,
  input  logic                         ref_a_i,
  input  logic                         ref_b_i,
  input  logic                         bp_c4_i,
  input  logic                         bp_fp_i,
  output logic                         osc_en_o,
  output logic [2:0]                   ref_sel_o,
  output logic                         ref_o,
  output logic                         frame_pulse_o,
  output logic [$clog2(FRAME_LEN)-1:0] frame_pos_o,
  output logic                         master_o,
  output logic [2:0]                   active_mode_o,
  output logic                         config_error_o
);

  localparam int CW = $clog2(FRAME_LEN);

  logic [NUM_SRC-1:0] src_vec;
  logic [NUM_SRC-1:0] rise_vec;
  logic [2:0]         active_q;
  logic [2:0]         active_d;
  logic               cfg_err_q;
  logic               cfg_err_d;
  logic               align;
  logic               wrap;
  rsel_e              rsel;

  assign src_vec[SRC_BP]  = bp_fp_i;
  assign src_vec[SRC_REC] = ref_rec_i;
  assign src_vec[SRC_A]   = ref_a_i;
  assign src_vec[SRC_B]   = ref_b_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    ftc_edge_sync u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (src_vec[g]),
      .rise_o  (rise_vec[g])
    );
  end

  ftc_prescaler #(.CNT_W(2)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_code_i (xdiv_i),
    .en_o       (osc_en_o)
  );

  assign align = mode_aligns(active_q) && rise_vec[active_q[1:0]];

  ftc_frame_counter #(.FRAME_LEN(FRAME_LEN)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .align_i (align),
    .pos_o   (frame_pos_o),
    .wrap_o  (wrap),
    .pulse_o (frame_pulse_o)
  );

  // mode register: zero request is immediate, others wait for a wrap
  always_comb begin
    active_d = active_q;
    if (mode_i == MODE_FREE) active_d = MODE_FREE;
    else if (wrap)           active_d = mode_i;
  end

  always_comb begin
    cfg_err_d = (xdiv_i == 2'b11) || ((xdiv_i != 2'b00) && (mode_i != MODE_FREE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= MODE_FREE;
      cfg_err_q <= 1'b0;
    end else begin
      active_q  <= active_d;
      cfg_err_q <= cfg_err_d;
    end
  end

  assign rsel = mode_to_rsel(active_q);

  always_comb begin
    case (rsel)
      RSEL_REC: ref_o = ref_rec_i;
      RSEL_A:   ref_o = ref_a_i;
      RSEL_B:   ref_o = ref_b_i;
      RSEL_BP:  ref_o = bp_c4_i;
      default:  ref_o = osc_en_o;
    endcase
  end

  assign ref_sel_o      = rsel;
  assign master_o       = (active_q != MODE_BP_SLAVE);
  assign active_mode_o  = active_q;
  assign config_error_o = cfg_err_q;

  assert_mode_only_at_wrap_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != $past(active_q)) |-> ($past(wrap) || active_q == MODE_FREE));

  assert_zero_immediate_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_FREE) |=> (active_q == MODE_FREE));

  assert_reserved_div_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    (xdiv_i == 2'b11) |=> config_error_o);

  assert_no_align_free_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q[2] && tick_i && frame_pos_o != CW'(FRAME_LEN - 1))
      |=> (frame_pos_o != '0));

endmodule

// File: tb/frame_timing_ctrl_bench.sv
module frame_timing_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME_LEN  = 512;
  localparam int CW         = $clog2(FRAME_LEN);

  logic          clk;
  logic          rst_n;
  logic [2:0]    mode_i;
  logic [1:0]    xdiv_i;
  logic          tick_i;
  logic          ref_rec_i, ref_a_i, ref_b_i, bp_c4_i, bp_fp_i;
  logic          osc_en_o;
  logic [2:0]    ref_sel_o;
  logic          ref_o;
  logic          frame_pulse_o;
  logic [CW-1:0] frame_pos_o;
  logic          master_o;
  logic [2:0]    active_mode_o;
  logic          config_error_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  frame_timing_ctrl #(.FRAME_LEN(FRAME_LEN)) u_frame_timing_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .xdiv_i(xdiv_i), .tick_i(tick_i),
    .ref_rec_i(ref_rec_i), .ref_a_i(ref_a_i), .ref_b_i(ref_b_i),
    .bp_c4_i(bp_c4_i), .bp_fp_i(bp_fp_i), .osc_en_o(osc_en_o),
    .ref_sel_o(ref_sel_o), .ref_o(ref_o), .frame_pulse_o(frame_pulse_o),
    .frame_pos_o(frame_pos_o), .master_o(master_o),
    .active_mode_o(active_mode_o), .config_error_o(config_error_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_pos(input int p);
    for (int i = 0; i < 4*FRAME_LEN; i++) begin
      if (frame_pos_o == CW'(p)) return;
      @(negedge clk);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode_i = m;
    for (int i = 0; i < 3*FRAME_LEN; i++) begin
      @(negedge clk);
      if (active_mode_o == m) return;
    end
  endtask

  task automatic drive_src(input int idx, input logic v);
    case (idx)
      0: bp_fp_i   = v;
      1: ref_rec_i = v;
      2: ref_a_i   = v;
      default: ref_b_i = v;
    endcase
  endtask

  // raise a source at a negedge and look after the third rising edge
  task automatic edge_probe(input int idx, input bit expect_align, input string req);
    wait_pos(200);
    drive_src(idx, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req, frame_pos_o, expect_align ? 0 : 203);
    if (expect_align) chk(req, frame_pulse_o, 1);
    drive_src(idx, 1'b0);
    step(3);
  endtask

  task automatic t_reset;
    chk("R1 active", active_mode_o, 0);
    chk("R1 master", master_o, 1);
    chk("R1 pos", frame_pos_o, 0);
    chk("R1 pulse", frame_pulse_o, 1);
    chk("R1 refsel", ref_sel_o, 0);
    chk("R1 cfgerr", config_error_o, 0);
  endtask

  task automatic t_prescaler;
    int exp_ones [4] = '{2, 4, 8, 2};
    for (int c = 0; c < 4; c++) begin
      int ones = 0;
      xdiv_i = 2'(c);
      step(2);
      for (int k = 0; k < 8; k++) begin
        ones += int'(osc_en_o);
        @(negedge clk);
      end
      chk("R2 osc_en rate", ones, exp_ones[c]);
      chk("R11 cfgerr mode0", config_error_o, (c == 3) ? 1 : 0);
    end
    xdiv_i = 2'b00;
    step(1);
    chk("R3 local ref", ref_sel_o, 0);
  endtask

  task automatic t_free_run;
    int p;
    wait_pos(509);
    step(1);
    chk("R4 pulse low", frame_pulse_o, 0);
    step(2);
    chk("R4 wrap", frame_pos_o, 0);
    chk("R4 pulse high", frame_pulse_o, 1);
    step(1);
    chk("R4 after wrap", frame_pos_o, 1);
    tick_i = 1'b0;
    step(3);
    chk("R4 hold", frame_pos_o, 1);
    tick_i = 1'b1;
    for (int s = 0; s < 4; s++) edge_probe(s, 1'b0, "R5 mode0 ignore");
    p = frame_pos_o;
    step(5);
    chk("R4 free run", frame_pos_o, (p + 5) % FRAME_LEN);
  endtask

  task automatic t_config;
    xdiv_i = 2'b01;
    mode_i = 3'd1;
    step(1);
    chk("R11 nonzero div nonzero mode", config_error_o, 1);
    xdiv_i = 2'b00;
    step(1);
    chk("R11 clear", config_error_o, 0);
    mode_i = 3'd0;
    step(1);
  endtask

  task automatic t_freq_mode;
    set_mode(3'd2);
    chk("R3 refsel A", ref_sel_o, 2);
    ref_a_i = 1'b1; #1;
    chk("R3 ref follows A", ref_o, 1);
    ref_a_i = 1'b0; #1;
    chk("R3 ref follows A low", ref_o, 0);
    chk("R8 master freq", master_o, 1);
    edge_probe(2, 1'b0, "R5 freq ignore A");
  endtask

  task automatic t_bp_slave;
    set_mode(3'd4);
    chk("R8 master clear", master_o, 0);
    chk("R3 refsel bp", ref_sel_o, 4);
    bp_c4_i = 1'b1; #1;
    chk("R3 ref follows c4", ref_o, 1);
    bp_c4_i = 1'b0;
    edge_probe(0, 1'b1, "R6 bp realign");
    edge_probe(2, 1'b0, "R6 bp ignore A");
  endtask

  task automatic t_align_a;
    set_mode(3'd6);
    chk("R8 master align", master_o, 1);
    chk("R3 refsel A align", ref_sel_o, 2);
    edge_probe(3, 1'b0, "R6 ignore B");
    edge_probe(2, 1'b1, "R6 A realign");
  endtask

  task automatic t_zero_collision;
    set_mode(3'd5);
    wait_pos(510);
    ref_rec_i = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7 natural zero", frame_pos_o, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 no reload at zero", frame_pos_o, 1);
    chk("R7 no second pulse", frame_pulse_o, 0);
    ref_rec_i = 1'b0;
    step(3);
  endtask

  task automatic t_mode_boundary;
    wait_pos(300);
    mode_i = 3'd7;
    wait_pos(511);
    chk("R9 held before wrap", active_mode_o, 5);
    step(1);
    chk("R9 taken at wrap", active_mode_o, 7);
    chk("R9 pos at switch", frame_pos_o, 0);
  endtask

  task automatic t_immediate_zero;
    wait_pos(100);
    mode_i = 3'd0;
    step(1);
    chk("R10 immediate", active_mode_o, 0);
    chk("R10 pos continues", frame_pos_o, 101);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_i = 3'd0; xdiv_i = 2'b00; tick_i = 1'b1;
    ref_rec_i = 1'b0; ref_a_i = 1'b0; ref_b_i = 1'b0; bp_c4_i = 1'b0; bp_fp_i = 1'b0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    t_prescaler();
    t_free_run();
    t_config();
    t_freq_mode();
    t_bp_slave();
    t_align_a();
    t_zero_collision();
    t_mode_boundary();
    t_immediate_zero();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule